// File: doc/BRIEF.md
# UART transmitter with dual flow control

This block serialises bytes into asynchronous 8N1 frames on a single output line and holds back new frames under two independent flow control schemes. The hardware scheme watches a clear-to-send input. The software scheme watches the byte stream from a companion receiver for pause (13h) and resume (11h) characters. Bytes enter on a valid/ready handshake. Each bit lasts a parameterised number of clock cycles.

Bytes from the receiver are handed upward one cycle after they arrive. While the software scheme is enabled, the pause and resume characters are consumed and not handed upward. A frame that has begun always runs to its stop bit. Either scheme only decides whether the next start bit may begin.

Top module: `uart_tx_flow`

## Requirements
- R1: Each frame is a 0 start bit, then the 8 data bits least significant first, then a 1 stop bit. Every bit lasts CLKS_PER_BIT cycles, and the line rests at 1 between frames.
- R2: A byte is accepted on a cycle with tx_valid_i and tx_ready_o both high. tx_ready_o stays low from acceptance until the stop bit has ended.
- R3: With hw_fc_en_i = 1, a frame may start only while the synchronised cts_i is 1 (1 = clear to send). While cts_i is 0, tx_ready_o stays 0 and the line stays at 1.
- R4: A frame in progress is sent in full even if cts_i falls to 0 partway through it.
- R5: With sw_fc_en_i = 1, a received 13h pauses transmission: tx_ready_o goes to 0 and no new frame starts. A received 11h resumes it. Repeated 13h or 11h bytes have the same effect as one.
- R6: With sw_fc_en_i = 1, received 11h and 13h are not forwarded. Any other received byte appears on rx_data_o with a one-cycle rx_valid_o pulse in the cycle after rx_valid_i.
- R7: With sw_fc_en_i = 0, every received byte is forwarded, including 11h and 13h. These bytes then leave transmission unaffected.
- R8: With hw_fc_en_i = 0, cts_i is ignored and is treated as always clear to send.
- R9: After reset, txd_o = 1, rx_valid_o = 0 and the software state is "resumed".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_fc_en_i | input | 1 | Enable clear-to-send gating |
| sw_fc_en_i | input | 1 | Enable pause/resume character gating |
| cts_i | input | 1 | Clear to send, asynchronous, 1 = send allowed |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Transmitter accepts a byte this cycle |
| txd_o | output | 1 | Serial output line |
| rx_data_i | input | 8 | Byte from the receiver |
| rx_valid_i | input | 1 | rx_data_i valid, one-cycle pulse |
| rx_data_o | output | 8 | Forwarded received byte |
| rx_valid_o | output | 1 | rx_data_o valid, one-cycle pulse |

## Verification
The assertions take several things for granted. rx_valid_i arrives as isolated one-cycle pulses with rx_data_i valid in that cycle. The flow control enables change only while no frame is in flight. cts_i may change at any time, because it is synchronised before use. The bench drives every input on the falling clock edge. It injects received bytes as single-cycle pulses, and it toggles the enables only between frames. It drops cts_i in the middle of a frame on purpose, to exercise the path where a frame must complete anyway.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);
  localparam logic [BYTE_W-1:0] RESUME_CHAR = 8'h11;
  localparam logic [BYTE_W-1:0] PAUSE_CHAR  = 8'h13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = sync_q[STAGES-1];
endmodule

// File: rtl/fc_rx_filter.sv
module fc_rx_filter
  import uart_fc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_fc_en_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              paused_o
);
  logic is_pause, is_resume, consume;
  logic [BYTE_W-1:0] data_q;
  logic valid_q, paused_q;

  assign is_pause  = (rx_data_i == PAUSE_CHAR);
  assign is_resume = (rx_data_i == RESUME_CHAR);
  assign consume   = sw_fc_en_i && (is_pause || is_resume);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q   <= '0;
      valid_q  <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      valid_q <= rx_valid_i && !consume;
      if (rx_valid_i && !consume) data_q <= rx_data_i;
      if (rx_valid_i && sw_fc_en_i) begin
        if (is_pause)       paused_q <= 1'b1;
        else if (is_resume) paused_q <= 1'b0;
      end
    end
  end

  assign rx_data_o  = data_q;
  assign rx_valid_o = valid_q;
  assign paused_o   = paused_q;

  a_r6_ctrl_not_forwarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !($past(sw_fc_en_i) &&
                     (rx_data_o == PAUSE_CHAR || rx_data_o == RESUME_CHAR)));
  a_r5_pause_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && sw_fc_en_i && is_pause) |=> paused_o);
  a_r5_resume_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && sw_fc_en_i && is_resume) |=> !paused_o);
  a_r6_forward_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !consume) |=> (rx_valid_o && rx_data_o == $past(rx_data_i)));
endmodule

// File: rtl/fc_tx_serializer.sv
module fc_tx_serializer
  import uart_fc_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o
);
  localparam int unsigned CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0]     CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [BIT_IDX_W-1:0] IDX_LAST = BIT_IDX_W'(BYTE_W - 1);

  tx_state_e state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [BIT_IDX_W-1:0] idx_q;
  logic [BYTE_W-1:0]    shift_q;
  logic                 txd_q;
  logic                 bit_end;

  assign bit_end = (cnt_q == CNT_LAST);
  assign ready_o = (state_q == ST_IDLE) && go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      txd_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          txd_q <= 1'b1;
          cnt_q <= '0;
          if (valid_i && ready_o) begin
            shift_q <= data_i;
            txd_q   <= 1'b0;
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (bit_end) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            txd_q   <= shift_q[0];
            state_q <= ST_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (idx_q == IDX_LAST) begin
              txd_q   <= 1'b1;
              state_q <= ST_STOP;
            end else begin
              idx_q   <= idx_q + 1'b1;
              shift_q <= shift_q >> 1;
              txd_q   <= shift_q[1];
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (bit_end) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end

  assign txd_o = txd_q;

  a_r1_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !txd_o);
  a_r1_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && cnt_q != '0) |-> $stable(txd_o));
  a_r1_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> txd_o);
  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);
endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_fc_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hw_fc_en_i,
  input  logic        sw_fc_en_i,
  input  logic        cts_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic        txd_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o
);
  logic cts_sync, paused, cts_ok, go;

  fc_cts_sync #(.STAGES(SYNC_STAGES)) i_cts_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cts_i),
    .sync_o  (cts_sync)
  );

  fc_rx_filter i_rx_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sw_fc_en_i (sw_fc_en_i),
    .rx_data_i  (rx_data_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .paused_o   (paused)
  );

  assign cts_ok = !hw_fc_en_i || cts_sync;
  assign go     = cts_ok && !(sw_fc_en_i && paused);

  fc_tx_serializer #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .ready_o (tx_ready_o),
    .txd_o   (txd_o)
  );

  a_r3_ready_needs_cts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_fc_en_i && tx_ready_o) |-> cts_sync);
  a_r5_paused_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_fc_en_i && paused) |-> !tx_ready_o);
endmodule

// File: tb/test_uart_tx_flow.sv
`timescale 1ns/1ps
module test_uart_tx_flow;
  localparam int C = 8;

  typedef struct packed {
    logic [7:0] d;
    logic       hw;
    logic       sw;
    logic       cts;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{8'h00, 1'b0, 1'b0, 1'b0},
    '{8'hFF, 1'b0, 1'b1, 1'b0},
    '{8'hA5, 1'b1, 1'b0, 1'b1},
    '{8'h5A, 1'b1, 1'b1, 1'b1},
    '{8'h01, 1'b0, 1'b1, 1'b1},
    '{8'h80, 1'b0, 1'b0, 1'b0}
  };

  logic clk = 0, rst_ni = 0;
  logic hw_en = 0, sw_en = 0, cts = 0;
  logic [7:0] tx_data = 0, rx_data = 0;
  logic tx_valid = 0, rx_valid = 0;
  logic tx_ready, txd, rx_valid_o;
  logic [7:0] rx_data_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  uart_tx_flow #(.CLKS_PER_BIT(C)) i_uart_tx_flow (
    .clk_i(clk), .rst_ni(rst_ni), .hw_fc_en_i(hw_en), .sw_fc_en_i(sw_en),
    .cts_i(cts), .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .txd_o(txd), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int drop_at,
                            output logic [7:0] got, output bit started);
    int w;
    started = 0;
    got = '0;
    @(negedge clk);
    tx_valid = 1;
    tx_data = d;
    w = 0;
    while (!tx_ready && w < 100) begin
      @(negedge clk);
      w++;
    end
    if (!tx_ready) begin
      tx_valid = 0;
      return;
    end
    started = 1;
    @(negedge clk);
    tx_valid = 0;
    repeat (C/2 - 1) @(negedge clk);
    chk(txd == 1'b0, "R1 start bit", {31'b0, txd}, 0);
    chk(tx_ready == 1'b0, "R2 ready low in frame", {31'b0, tx_ready}, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (C) @(negedge clk);
      if (i == drop_at) cts = 0;
      got[i] = txd;
      chk(tx_ready == 1'b0, "R2 ready low in frame", {31'b0, tx_ready}, 0);
    end
    repeat (C) @(negedge clk);
    chk(txd == 1'b1, "R1 stop bit", {31'b0, txd}, 1);
    repeat (C/2 + 2) @(negedge clk);
  endtask

  task automatic inject(input logic [7:0] d, output logic v, output logic [7:0] q);
    @(negedge clk);
    rx_valid = 1;
    rx_data = d;
    @(negedge clk);
    rx_valid = 0;
    v = rx_valid_o;
    q = rx_data_o;
    @(negedge clk);
  endtask

  task automatic hold_blocked(input string req);
    @(negedge clk);
    tx_valid = 1;
    tx_data = 8'h3C;
    for (int i = 0; i < 5 * C; i++) begin
      @(negedge clk);
      if (tx_ready || !txd) begin
        chk(1'b0, req, {30'b0, tx_ready, txd}, 1);
        break;
      end
    end
    chk(tx_ready == 1'b0 && txd == 1'b1, req, {30'b0, tx_ready, txd}, 1);
    tx_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2 actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got, q;
    logic v;
    bit st;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R9 txd idle in reset", {31'b0, txd}, 1);
    chk(rx_valid_o == 1'b0, "R9 rx_valid_o in reset", {31'b0, rx_valid_o}, 0);
    rst_ni = 1;
    sw_en = 1;
    repeat (2) @(negedge clk);
    chk(tx_ready == 1'b1, "R9 resumed after reset", {31'b0, tx_ready}, 1);

    // R1, R8 table of frames
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      hw_en = VECS[k].hw;
      sw_en = VECS[k].sw;
      cts = VECS[k].cts;
      repeat (4) @(negedge clk);
      send_frame(VECS[k].d, -1, got, st);
      chk(st, "R8 frame started", {31'b0, st}, 1);
      chk(got == VECS[k].d, "R1 data bits", {24'b0, got}, {24'b0, VECS[k].d});
      chk(tx_ready == 1'b1, "R2 ready after stop", {31'b0, tx_ready}, 1);
    end

    // R3 CTS off blocks
    @(negedge clk);
    hw_en = 1;
    sw_en = 0;
    cts = 0;
    repeat (4) @(negedge clk);
    hold_blocked("R3 blocked while cts off");
    cts = 1;
    send_frame(8'hC3, -1, got, st);
    chk(st && got == 8'hC3, "R3 sends after cts on", {24'b0, got}, 32'hC3);

    // R4 CTS drops mid-frame
    send_frame(8'h96, 3, got, st);
    chk(st && got == 8'h96, "R4 frame completes", {24'b0, got}, 32'h96);
    chk(tx_ready == 1'b0 && txd == 1'b1, "R4 no new frame after cts off", {30'b0, tx_ready, txd}, 1);

    // R8 hw off ignores cts
    @(negedge clk);
    hw_en = 0;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R8 cts ignored", {31'b0, tx_ready}, 1);

    // R5, R6 software pause / resume
    sw_en = 1;
    inject(8'h13, v, q);
    chk(v == 1'b0, "R6 pause char dropped", {31'b0, v}, 0);
    inject(8'h13, v, q);
    chk(tx_ready == 1'b0, "R5 paused", {31'b0, tx_ready}, 0);
    hold_blocked("R5 no frame while paused");
    inject(8'h41, v, q);
    chk(v == 1'b1 && q == 8'h41, "R6 data forwarded", {23'b0, v, q}, 32'h141);
    inject(8'h11, v, q);
    chk(v == 1'b0, "R6 resume char dropped", {31'b0, v}, 0);
    chk(tx_ready == 1'b1, "R5 resumed after one 11h", {31'b0, tx_ready}, 1);
    inject(8'h11, v, q);
    chk(tx_ready == 1'b1, "R5 repeated 11h", {31'b0, tx_ready}, 1);
    send_frame(8'h7E, -1, got, st);
    chk(st && got == 8'h7E, "R5 sends after resume", {24'b0, got}, 32'h7E);

    // R7 software control off
    @(negedge clk);
    sw_en = 0;
    inject(8'h13, v, q);
    chk(v == 1'b1 && q == 8'h13, "R7 13h forwarded", {23'b0, v, q}, 32'h113);
    chk(tx_ready == 1'b1, "R7 13h no pause", {31'b0, tx_ready}, 1);
    inject(8'h11, v, q);
    chk(v == 1'b1 && q == 8'h11, "R7 11h forwarded", {23'b0, v, q}, 32'h111);
    @(negedge clk);
    sw_en = 1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R7 state untouched", {31'b0, tx_ready}, 1);
    send_frame(8'h24, -1, got, st);
    chk(st && got == 8'h24, "R7 sends", {24'b0, got}, 32'h24);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule